// File: doc/BRIEF.md
# Load-Exclusive Reservation Monitor

This block tracks one reservation per core for load-linked / store-conditional semaphore sequences. When the core presents a load-exclusive, the monitor records the word address and marks the reservation valid. When the core later presents a store-exclusive, the monitor lets the write out onto the shared bus only if the reservation is still held and covers the same word. The store then counts as successful only if the interconnect answers with an exclusive-okay response. The outcome goes back to the core as a carry flag: 0 on success, 1 on failure.

Several things end the reservation. An ordinary store by another bus master to the reserved word is seen on the snoop input and kills it. An interrupt, an exception or a break event also clears it, and so does reset. Every store-exclusive clears it as well, whatever the outcome. Addresses are compared at word granularity, so the two lowest address bits play no part.

The load-exclusive gets no reply from this block, because the data read travels on another path. A store-exclusive gets exactly one reply pulse. While a store-exclusive waits for its bus response, the block accepts no new request.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation is invalid, the carry flag is 0, `coreReqReady` is 1 and neither `busWrValid` nor `coreRespValid` is asserted. A store-exclusive issued before any load-exclusive therefore fails.
- R2: A store-exclusive (`coreReqStore`=1) to the word held by a valid reservation raises `busWrValid` for exactly one cycle, in the cycle after the request. It carries the request's address and data. An exclusive-okay response (`busRespExOkay`=1) then gives `coreRespValid` with `coreRespCarry`=0.
- R3: When the issued write is answered with `busRespExOkay`=0, the store-exclusive fails and reports `coreRespCarry`=1.
- R4: A snooped external write (`snoopValid`=1) to the reserved word kills the reservation, and a later store-exclusive to that word fails without a bus write. A snooped write to a different word leaves the reservation intact.
- R5: Any of `evtIrq`, `evtExc` or `evtBrk` clears the reservation, so the next store-exclusive fails without a bus write. An event in the same cycle as a load-exclusive wins, and no reservation is set.
- R6: An exception (for example a translation miss) in the same cycle as a store-exclusive request stops the write from going out. The store fails and the reservation is cleared.
- R7: Every store-exclusive clears the reservation, whether it succeeds or fails. A second store-exclusive with no load-exclusive in between fails.
- R8: A store-exclusive to a word other than the reserved one fails without a bus write. Address bits [1:0] are ignored in every comparison.
- R9: A snooped write and a store-exclusive to the reserved word in the same cycle resolve in favour of the snooped write: the store fails with no bus write.
- R10: A new load-exclusive replaces the reserved word and keeps the reservation valid. A snooped write to the reserved word in the same cycle as the load-exclusive does not cancel the new reservation.
- R11: A failing store-exclusive reports `coreRespValid`=1 with carry 1 in the cycle after the request. Once a write has been issued, `coreReqReady` stays 0 until the bus response is taken. `coreRespValid` follows one cycle after `busRespValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreReqValid | input | 1 | Core presents an exclusive access |
| coreReqStore | input | 1 | 0 = load-exclusive, 1 = store-exclusive |
| coreReqAddr | input | 32 | Byte address of the access |
| coreReqData | input | 32 | Store-exclusive write data |
| coreReqReady | output | 1 | Monitor can accept a request this cycle |
| coreRespValid | output | 1 | One-cycle pulse: store-exclusive result valid |
| coreRespCarry | output | 1 | Carry flag: 1 = last store-exclusive failed |
| busWrValid | output | 1 | One-cycle exclusive write request to the interconnect |
| busWrAddr | output | 32 | Write address |
| busWrData | output | 32 | Write data |
| busRespValid | input | 1 | Interconnect write response valid |
| busRespExOkay | input | 1 | Response is exclusive-okay |
| snoopValid | input | 1 | Another master performs an ordinary store |
| snoopAddr | input | 32 | Address of the snooped store |
| evtIrq | input | 1 | Interrupt taken |
| evtExc | input | 1 | Exception raised |
| evtBrk | input | 1 | Break event or break instruction |

## Verification
Two functions can fall in the same cycle here: a store-exclusive that checks the reservation, and a kill of that reservation by a snooped store or a core event. The bench provokes this on purpose. It lines up a snooped write and a store-exclusive to the same word in one cycle. It also raises an exception together with a store-exclusive, and a snoop or an event together with a load-exclusive. Each result is judged against a bench model of the reservation with fixed priorities: a kill beats the store-exclusive, an event beats a new load-exclusive, and a new load-exclusive beats a snoop. The bench checks whether a bus write appeared and the value of the carry flag.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic setResv;   // record request word, reservation valid
    logic clrResv;   // drop reservation
    logic issueWr;   // launch exclusive bus write
    logic failNow;   // report immediate failure
    logic takeResp;  // capture bus response into carry
  } ctrlStrobe_t;

endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              respExOkay,
  output logic              resvHit,
  output logic              snoopHit,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              respValid,
  output logic              carryFlag
);

  localparam int WORD_W = ADDR_W - GRAN_LSB;

  logic              resvValid;
  logic [WORD_W-1:0] resvWord;
  logic [WORD_W-1:0] reqWord;
  logic [WORD_W-1:0] snoopWord;

  assign reqWord   = reqAddr[ADDR_W-1:GRAN_LSB];
  assign snoopWord = snoopAddr[ADDR_W-1:GRAN_LSB];

  // Match of the current request and of a snooped store against the reservation
  assign resvHit  = resvValid && (reqWord == resvWord);
  assign snoopHit = resvValid && snoopValid && (snoopWord == resvWord);

  // Reservation register: clear has priority over set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvValid <= 1'b0;
      resvWord  <= '0;
    end else if (strobe.clrResv) begin
      resvValid <= 1'b0;
    end else if (strobe.setResv) begin
      resvValid <= 1'b1;
      resvWord  <= reqWord;
    end
  end

  // Bus write launch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= strobe.issueWr;
      if (strobe.issueWr) begin
        wrAddr <= reqAddr;
        wrData <= reqData;
      end
    end
  end

  // Result to the core
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      carryFlag <= 1'b0;
    end else begin
      respValid <= strobe.failNow | strobe.takeResp;
      if (strobe.failNow) begin
        carryFlag <= 1'b1;
      end else if (strobe.takeResp) begin
        carryFlag <= ~respExOkay;
      end
    end
  end

endmodule

// File: rtl/resv_control.sv
module resv_control
  import resv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqStore,
  input  logic        resvHit,
  input  logic        snoopHit,
  input  logic        busRespValid,
  input  logic        evtIrq,
  input  logic        evtExc,
  input  logic        evtBrk,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  ctrlState_t state, stateNext;
  logic       reqFire;
  logic       coreEvt;
  logic       stxFire;
  logic       ldxFire;

  assign reqReady = (state == ST_IDLE);
  assign reqFire  = reqValid && reqReady;
  assign coreEvt  = evtIrq | evtExc | evtBrk;
  assign stxFire  = reqFire && reqStore;
  assign ldxFire  = reqFire && !reqStore;

  always_comb begin
    strobe          = '0;
    // A core event in the same cycle blocks a new reservation
    strobe.setResv  = ldxFire && !coreEvt;
    // A new load-exclusive overrides a snoop of the old word
    strobe.clrResv  = coreEvt || stxFire || (snoopHit && !strobe.setResv);
    // Snoop and events beat the store-exclusive
    strobe.issueWr  = stxFire && resvHit && !snoopHit && !coreEvt;
    strobe.failNow  = stxFire && !strobe.issueWr;
    strobe.takeResp = (state == ST_WAIT) && busRespValid;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.issueWr)  stateNext = ST_WAIT;
      ST_WAIT: if (strobe.takeResp) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreReqValid,
  input  logic              coreReqStore,
  input  logic [ADDR_W-1:0] coreReqAddr,
  input  logic [DATA_W-1:0] coreReqData,
  output logic              coreReqReady,
  output logic              coreRespValid,
  output logic              coreRespCarry,
  output logic              busWrValid,
  output logic [ADDR_W-1:0] busWrAddr,
  output logic [DATA_W-1:0] busWrData,
  input  logic              busRespValid,
  input  logic              busRespExOkay,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              evtIrq,
  input  logic              evtExc,
  input  logic              evtBrk
);

  ctrlStrobe_t strobe;
  logic        resvHit;
  logic        snoopHit;

  resv_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (coreReqValid),
    .reqStore     (coreReqStore),
    .resvHit      (resvHit),
    .snoopHit     (snoopHit),
    .busRespValid (busRespValid),
    .evtIrq       (evtIrq),
    .evtExc       (evtExc),
    .evtBrk       (evtBrk),
    .reqReady     (coreReqReady),
    .strobe       (strobe)
  );

  resv_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .GRAN_LSB (GRAN_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (coreReqAddr),
    .reqData    (coreReqData),
    .snoopValid (snoopValid),
    .snoopAddr  (snoopAddr),
    .respExOkay (busRespExOkay),
    .resvHit    (resvHit),
    .snoopHit   (snoopHit),
    .wrValid    (busWrValid),
    .wrAddr     (busWrAddr),
    .wrData     (busWrData),
    .respValid  (coreRespValid),
    .carryFlag  (coreRespCarry)
  );

endmodule

// File: rtl/resv_monitor_sva.sv
module resv_monitor_sva #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              coreReqValid,
  input logic              coreReqStore,
  input logic [ADDR_W-1:0] coreReqAddr,
  input logic              coreReqReady,
  input logic              coreRespValid,
  input logic              coreRespCarry,
  input logic              busWrValid,
  input logic [ADDR_W-1:0] busWrAddr,
  input logic              busRespValid,
  input logic              busRespExOkay,
  input logic              snoopValid,
  input logic [ADDR_W-1:0] snoopAddr,
  input logic              evtIrq,
  input logic              evtExc,
  input logic              evtBrk
);

  logic stxFire;
  assign stxFire = coreReqValid && coreReqReady && coreReqStore;

  // R2: a bus write only follows an accepted store-exclusive, to its word
  a_r2_wr_follows_stx: assert property (@(posedge clk) disable iff (!rstN)
    busWrValid |-> ($past(stxFire) &&
      $past(coreReqAddr[ADDR_W-1:GRAN_LSB]) == busWrAddr[ADDR_W-1:GRAN_LSB]));

  // R2: write request lasts one cycle
  a_r2_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    busWrValid |=> !busWrValid);

  // R3: non-exclusive-okay answer gives carry 1
  a_r3_bad_resp: assert property (@(posedge clk) disable iff (!rstN)
    (busRespValid && !busRespExOkay && !coreReqReady) |=> (coreRespValid && coreRespCarry));

  // R6 / R5: event together with a store-exclusive blocks the write
  a_r6_evt_blocks_wr: assert property (@(posedge clk) disable iff (!rstN)
    (stxFire && (evtIrq || evtExc || evtBrk)) |=> (!busWrValid && coreRespValid && coreRespCarry));

  // R9: same-cycle snoop to the store word wins
  a_r9_snoop_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stxFire && snoopValid &&
     snoopAddr[ADDR_W-1:GRAN_LSB] == coreReqAddr[ADDR_W-1:GRAN_LSB]) |=> !busWrValid);

  // R11: every store-exclusive yields either a write or an immediate result
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    stxFire |=> (busWrValid != coreRespValid));

  // R11: no new request accepted while a write is outstanding
  a_r11_busy: assert property (@(posedge clk) disable iff (!rstN)
    busWrValid |-> !coreReqReady);

endmodule

bind resv_monitor resv_monitor_sva #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .GRAN_LSB (GRAN_LSB)
) u_sva (
  .clk           (clk),
  .rstN          (rstN),
  .coreReqValid  (coreReqValid),
  .coreReqStore  (coreReqStore),
  .coreReqAddr   (coreReqAddr),
  .coreReqReady  (coreReqReady),
  .coreRespValid (coreRespValid),
  .coreRespCarry (coreRespCarry),
  .busWrValid    (busWrValid),
  .busWrAddr     (busWrAddr),
  .busRespValid  (busRespValid),
  .busRespExOkay (busRespExOkay),
  .snoopValid    (snoopValid),
  .snoopAddr     (snoopAddr),
  .evtIrq        (evtIrq),
  .evtExc        (evtExc),
  .evtBrk        (evtBrk)
);

// File: tb/resv_monitor_test.sv
`timescale 1ns/1ps
module resv_monitor_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        coreReqValid, coreReqStore;
  logic [31:0] coreReqAddr, coreReqData;
  logic        coreReqReady, coreRespValid, coreRespCarry;
  logic        busWrValid;
  logic [31:0] busWrAddr, busWrData;
  logic        busRespValid, busRespExOkay;
  logic        snoopValid;
  logic [31:0] snoopAddr;
  logic        evtIrq, evtExc, evtBrk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Bench reservation model
  bit          refValid;
  logic [29:0] refWord;

  always #2.5 clk = ~clk;

  resv_monitor uut (
    .clk(clk), .rstN(rstN),
    .coreReqValid(coreReqValid), .coreReqStore(coreReqStore),
    .coreReqAddr(coreReqAddr), .coreReqData(coreReqData),
    .coreReqReady(coreReqReady), .coreRespValid(coreRespValid),
    .coreRespCarry(coreRespCarry), .busWrValid(busWrValid),
    .busWrAddr(busWrAddr), .busWrData(busWrData),
    .busRespValid(busRespValid), .busRespExOkay(busRespExOkay),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .evtIrq(evtIrq), .evtExc(evtExc), .evtBrk(evtBrk)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit stxPasses(bit v, logic [29:0] rw, logic [31:0] a,
                                   bit sv, logic [31:0] sa, bit ev);
    return v && (a[31:2] == rw) && !ev && !(sv && sa[31:2] == rw);
  endfunction

  task automatic idleInputs();
    coreReqValid = 0; coreReqStore = 0; coreReqAddr = 0; coreReqData = 0;
    busRespValid = 0; busRespExOkay = 0; snoopValid = 0; snoopAddr = 0;
    evtIrq = 0; evtExc = 0; evtBrk = 0;
  endtask

  // One operation, entered and left at a negedge.
  // kind: 0 idle, 1 load-exclusive, 2 store-exclusive
  task automatic op(input int kind, input logic [31:0] a, input logic [31:0] d,
                    input bit sv, input logic [31:0] sa,
                    input bit irq, input bit exc, input bit brk,
                    input bit okResp, input int delay, input string req);
    bit ev = irq | exc | brk;
    bit pass;
    pass = (kind == 2) && stxPasses(refValid, refWord, a, sv, sa, ev);
    coreReqValid = (kind != 0); coreReqStore = (kind == 2);
    coreReqAddr = a; coreReqData = d;
    snoopValid = sv; snoopAddr = sa;
    evtIrq = irq; evtExc = exc; evtBrk = brk;
    // model update
    if (kind == 1) begin
      if (ev) refValid = 0;
      else begin refValid = 1; refWord = a[31:2]; end
    end else if (kind == 2) begin
      refValid = 0;
    end else if (ev || (sv && refValid && sa[31:2] == refWord)) begin
      refValid = 0;
    end
    @(negedge clk);
    idleInputs();
    if (kind != 2) begin
      chk(!busWrValid && !coreRespValid, req, {busWrValid, coreRespValid}, 0);
    end else if (!pass) begin
      chk(!busWrValid, req, busWrValid, 0);
      chk(coreRespValid && coreRespCarry, {req, " R11"}, {coreRespValid, coreRespCarry}, 2'b11);
    end else begin
      chk(busWrValid && busWrAddr == a && busWrData == d, req,
          {busWrValid, busWrAddr}, {1'b1, a});
      chk(!coreReqReady && !coreRespValid, "R11", {coreReqReady, coreRespValid}, 0);
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        chk(!coreReqReady && !busWrValid, "R11", {coreReqReady, busWrValid}, 0);
      end
      busRespValid = 1; busRespExOkay = okResp;
      @(negedge clk);
      idleInputs();
      chk(coreRespValid && coreRespCarry == !okResp, okResp ? req : "R3",
          {coreRespValid, coreRespCarry}, {1'b1, !okResp});
      chk(coreReqReady, "R11", coreReqReady, 1);
    end
  endtask

  function automatic logic [31:0] poolAddr(int sel);
    logic [31:0] base;
    case (sel % 4)
      0: base = 32'h0000_1000;
      1: base = 32'h0000_1004;
      2: base = 32'h0000_2000;
      default: base = 32'h1000_0000;
    endcase
    return base | ($urandom & 32'h3);
  endfunction

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    idleInputs();
    refValid = 0; refWord = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(coreReqReady && !busWrValid && !coreRespValid && !coreRespCarry, "R1",
        {coreReqReady, busWrValid, coreRespValid, coreRespCarry}, 4'b1000);
    op(2, 32'h1000, 32'hA, 0, 0, 0, 0, 0, 1, 0, "R1");

    // R2 success, low bits differ
    op(1, 32'h1001, 0, 0, 0, 0, 0, 0, 1, 0, "R2");
    op(2, 32'h1003, 32'hCAFE, 0, 0, 0, 0, 0, 1, 2, "R2");
    // R7 second store fails
    op(2, 32'h1000, 32'h1, 0, 0, 0, 0, 0, 1, 0, "R7");
    // R3 bad response
    op(1, 32'h2000, 0, 0, 0, 0, 0, 0, 1, 0, "R3");
    op(2, 32'h2000, 32'h5, 0, 0, 0, 0, 0, 0, 1, "R3");
    // R4 snoop kill, and snoop to other word harmless
    op(1, 32'h2000, 0, 0, 0, 0, 0, 0, 1, 0, "R4");
    op(0, 0, 0, 1, 32'h2004, 0, 0, 0, 1, 0, "R4");
    op(2, 32'h2002, 32'h7, 0, 0, 0, 0, 0, 1, 0, "R4");
    op(1, 32'h2000, 0, 0, 0, 0, 0, 0, 1, 0, "R4");
    op(0, 0, 0, 1, 32'h2003, 0, 0, 0, 1, 0, "R4");
    op(2, 32'h2000, 32'h7, 0, 0, 0, 0, 0, 1, 0, "R4");
    // R5 events
    op(1, 32'h3000, 0, 0, 0, 0, 0, 0, 1, 0, "R5");
    op(0, 0, 0, 0, 0, 1, 0, 0, 1, 0, "R5");
    op(2, 32'h3000, 32'h8, 0, 0, 0, 0, 0, 1, 0, "R5");
    op(1, 32'h3000, 0, 0, 0, 0, 0, 1, 1, 0, "R5");
    op(2, 32'h3000, 32'h8, 0, 0, 0, 0, 0, 1, 0, "R5");
    // R6 exception with store-exclusive
    op(1, 32'h4000, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
    op(2, 32'h4000, 32'h9, 0, 0, 0, 1, 0, 1, 0, "R6");
    op(2, 32'h4000, 32'h9, 0, 0, 0, 0, 0, 1, 0, "R6");
    // R8 other word
    op(1, 32'h5000, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    op(2, 32'h5004, 32'h1, 0, 0, 0, 0, 0, 1, 0, "R8");
    // R9 same-cycle snoop
    op(1, 32'h6000, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
    op(2, 32'h6000, 32'h2, 1, 32'h6002, 0, 0, 0, 1, 0, "R9");
    // R10 replacement, and snoop of old word during new load
    op(1, 32'h7000, 0, 0, 0, 0, 0, 0, 1, 0, "R10");
    op(1, 32'h7008, 0, 1, 32'h7000, 0, 0, 0, 1, 0, "R10");
    op(2, 32'h7000, 32'h3, 0, 0, 0, 0, 0, 1, 0, "R10");
    op(1, 32'h7000, 0, 0, 0, 0, 0, 0, 1, 0, "R10");
    op(1, 32'h7008, 0, 0, 0, 0, 0, 0, 1, 0, "R10");
    op(2, 32'h7009, 32'h4, 0, 0, 0, 0, 0, 1, 1, "R10");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 2);
      bit sv = ($urandom_range(0, 4) == 0);
      bit ev = ($urandom_range(0, 9) == 0);
      int which = $urandom_range(0, 2);
      op(k, poolAddr($urandom), $urandom, sv, poolAddr($urandom),
         ev && which == 0, ev && which == 1, ev && which == 2,
         $urandom_range(0, 3) != 0, $urandom_range(0, 3), "R2 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule